// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

A single timer channel that measures the spacing between valid edges on an asynchronous input. It runs on the operating clock and advances only in cycles where a count-enable pulse arrives. The counter width is a parameter, 16 bits by default. Each valid edge copies the running count into a capture register, restarts the count from zero and raises a one-cycle interrupt. Every capture after the first therefore holds the number of count pulses between two consecutive edges.

Software starts the channel with a start write. The counter keeps its old value until the first count pulse after the write. That pulse is the start trigger: it zeroes the counter and can also raise the interrupt. The first capture after start covers only part of an interval, but it is still stored and still interrupts. The input passes through one synchroniser stage. An optional glitch filter adds two cycles of delay and rejects levels that last a single cycle. A stop write freezes the channel.

Top module: `pulse_interval_timer`

## Requirements
- R1: After reset, `enabled`, `irq`, `count` and `capture` are all zero.
- R2: A start write sets `enabled` in the next cycle. Until the start trigger, `count` keeps the value it had before the write.
- R3: The first cycle with `cnt_en` high after enabling is the start trigger. It loads zero into `count`. It pulses `irq` in the next cycle only when `start_irq` is 1.
- R4: While running, each `cnt_en` cycle adds one to `count`. The count wraps from all-ones to zero without an interrupt.
- R5: A valid edge while running copies `count` into `capture`, sets `count` to zero and pulses `irq` for one cycle, all at the same clock edge.
- R6: `edge_sel` chooses the valid edge: 2'b00 is falling, 2'b01 is rising, and 2'b10 or 2'b11 is both.
- R7: Without the filter, an input change that is stable before clock edge k is captured at edge k+1. With `filt_en` set, the capture moves to edge k+3.
- R8: With `filt_en` set, a level that is sampled for only one cycle produces no capture and no interrupt. A level held for two cycles is accepted.
- R9: A stop write clears `enabled` in the next cycle. While disabled, `count` and `capture` hold their values and input edges cause no interrupt.
- R10: Between the start write and the start trigger, input edges cause no capture and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Active-low reset |
| cnt_en | input | 1 | Count-clock enable pulse |
| start_wr | input | 1 | Start write strobe |
| stop_wr | input | 1 | Stop write strobe; wins over start_wr |
| start_irq | input | 1 | Raise the interrupt at the start trigger |
| edge_sel | input | 2 | Valid-edge select |
| filt_en | input | 1 | Glitch filter enable |
| sig_in | input | 1 | Asynchronous capture input |
| capture | output | WIDTH | Last captured interval |
| count | output | WIDTH | Live counter value |
| enabled | output | 1 | Channel enabled flag |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench changes inputs 1 ns after a rising edge and samples 1 ns after a later edge. Start and stop show on `enabled` one edge after the write. The start trigger shows on `count` and `irq` at the edge of its count pulse. An unfiltered input change is captured two edges after it is driven, and a filtered one four edges after. The bench samples one edge earlier too, to confirm nothing has changed yet.

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             start_wr,
  input  logic             stop_wr,
  input  logic             start_irq,
  input  logic [1:0]       edge_sel,
  input  logic             filt_en,
  input  logic             sig_in,
  output logic [WIDTH-1:0] capture,
  output logic [WIDTH-1:0] count,
  output logic             enabled,
  output logic             irq
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic sync_q, dly1_q, dly2_q, lvl_q, pend_q;

  wire  stable2  = (dly1_q == dly2_q);
  wire  new_lvl  = filt_en ? (stable2 ? dly2_q : lvl_q) : sync_q;
  wire  changed  = new_lvl != lvl_q;
  wire  hit      = changed && (new_lvl ? (edge_sel != 2'b00) : (edge_sel != 2'b01));
  wire  running  = enabled && !pend_q;
  wire  trig     = enabled && pend_q && cnt_en;
  wire  cap_now  = running && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      dly1_q  <= 1'b0;
      dly2_q  <= 1'b0;
      lvl_q   <= 1'b0;
      pend_q  <= 1'b0;
      enabled <= 1'b0;
      irq     <= 1'b0;
      count   <= '0;
      capture <= '0;
    end else begin
      sync_q <= sig_in;
      dly1_q <= sync_q;
      dly2_q <= dly1_q;
      lvl_q  <= new_lvl;
      irq    <= (trig && start_irq) || cap_now;

      if (stop_wr) begin
        enabled <= 1'b0;
        pend_q  <= 1'b0;
      end else if (start_wr) begin
        enabled <= 1'b1;
        pend_q  <= 1'b1;
      end else if (trig) begin
        pend_q  <= 1'b0;
      end

      if (trig) begin
        count <= '0;
      end else if (cap_now) begin
        capture <= count;
        count   <= '0;
      end else if (running && cnt_en) begin
        count <= count + 1'b1;
      end
    end
  end

  assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !stop_wr) |=> enabled);
  assert_wait_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && pend_q && !cnt_en) |=> $stable(count));
  assert_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (count == '0) && (irq == $past(start_irq)));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt_en && !cap_now && count == ALL_ONES) |=> (count == '0) && !irq);
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |=> (capture == $past(count)) && (count == '0) && irq);
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> !enabled);
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> $stable(count) && $stable(capture) && !irq);
  assert_pend_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> $stable(capture));
endmodule

// File: tb/pulse_interval_timer_bench.sv
module pulse_interval_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, start_wr = 1'b0, stop_wr = 1'b0, start_irq = 1'b0;
  logic [1:0] edge_sel = 2'b01;
  logic filt_en = 1'b0, sig_in = 1'b0;
  logic [15:0] capture, count;
  logic enabled, irq;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  pulse_interval_timer u_pulse_interval_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start_wr(start_wr),
    .stop_wr(stop_wr), .start_irq(start_irq), .edge_sel(edge_sel),
    .filt_en(filt_en), .sig_in(sig_in), .capture(capture), .count(count),
    .enabled(enabled), .irq(irq));

  task automatic step();
    @(posedge clk);
    #1ns;
  endtask

  task automatic pulses(input int n);
    cnt_en = 1'b1;
    repeat (n) step();
    cnt_en = 1'b0;
  endtask

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1", "enabled", 16'(enabled), 16'd0);
    chk("R1", "irq", 16'(irq), 16'd0);
    chk("R1", "count", count, 16'd0);
    chk("R1", "capture", capture, 16'd0);
  endtask

  task automatic t_start_irq();
    start_irq = 1'b1;
    start_wr = 1'b1; step(); start_wr = 1'b0;
    chk("R2", "enabled after start", 16'(enabled), 16'd1);
    step(); step();
    chk("R2", "count before trigger", count, 16'd0);
    chk("R3", "no irq before trigger", 16'(irq), 16'd0);
    pulses(1);
    chk("R3", "count at trigger", count, 16'd0);
    chk("R3", "irq at trigger, mode 1", 16'(irq), 16'd1);
    step();
    chk("R3", "irq one cycle", 16'(irq), 16'd0);
  endtask

  task automatic t_count_and_rise();
    pulses(5);
    chk("R4", "count after 5", count, 16'd5);
    edge_sel = 2'b01;
    sig_in = 1'b1; step();
    chk("R7", "capture not yet", capture, 16'd0);
    chk("R7", "irq not yet", 16'(irq), 16'd0);
    step();
    chk("R5", "capture rising", capture, 16'd5);
    chk("R5", "count restart", count, 16'd0);
    chk("R5", "irq on capture", 16'(irq), 16'd1);
    step();
    chk("R5", "irq one cycle", 16'(irq), 16'd0);
  endtask

  task automatic t_select();
    pulses(3);
    sig_in = 1'b0; step(); step();
    chk("R6", "falling ignored when rising", capture, 16'd5);
    chk("R6", "count kept", count, 16'd3);
    chk("R6", "no irq", 16'(irq), 16'd0);
    edge_sel = 2'b10;
    sig_in = 1'b1; step(); step();
    chk("R6", "both: rising taken", capture, 16'd3);
    chk("R6", "both: irq", 16'(irq), 16'd1);
    edge_sel = 2'b00;
    pulses(4);
    sig_in = 1'b0; step(); step();
    chk("R6", "falling taken", capture, 16'd4);
    sig_in = 1'b1; step(); step();
    chk("R6", "rising ignored when falling", capture, 16'd4);
    chk("R6", "count after ignore", count, 16'd0);
  endtask

  task automatic t_filter();
    int irqs;
    filt_en = 1'b1; edge_sel = 2'b10; step();
    pulses(2);
    sig_in = 1'b0;
    repeat (3) step();
    chk("R7", "filtered not yet", capture, 16'd4);
    step();
    chk("R7", "filtered capture", capture, 16'd2);
    chk("R7", "filtered irq", 16'(irq), 16'd1);
    step();
    pulses(6);
    irqs = 0;
    sig_in = 1'b1; step(); sig_in = 1'b0;
    if (irq) irqs++;
    repeat (6) begin step(); if (irq) irqs++; end
    chk("R8", "glitch no irq", 16'(irqs), 16'd0);
    chk("R8", "glitch no capture", capture, 16'd2);
    chk("R8", "glitch count kept", count, 16'd6);
    sig_in = 1'b1; step(); step(); sig_in = 1'b0;
    step(); step();
    chk("R8", "two-cycle level accepted", capture, 16'd6);
    repeat (4) step();
    filt_en = 1'b0; step();
    pulses(7);
    sig_in = 1'b1; step(); step();
    chk("R5", "capture unfiltered again", capture, 16'd7);
  endtask

  task automatic t_stop();
    int irqs;
    pulses(9);
    stop_wr = 1'b1; step(); stop_wr = 1'b0;
    chk("R9", "enabled cleared", 16'(enabled), 16'd0);
    pulses(3);
    chk("R9", "count frozen", count, 16'd9);
    irqs = 0;
    sig_in = 1'b0;
    repeat (3) begin step(); if (irq) irqs++; end
    chk("R9", "capture held", capture, 16'd7);
    chk("R9", "no irq while stopped", 16'(irqs), 16'd0);
  endtask

  task automatic t_pending();
    int irqs;
    start_irq = 1'b0;
    start_wr = 1'b1; step(); start_wr = 1'b0;
    chk("R2", "enabled again", 16'(enabled), 16'd1);
    chk("R2", "old count held", count, 16'd9);
    irqs = 0;
    sig_in = 1'b1;
    repeat (3) begin step(); if (irq) irqs++; end
    sig_in = 1'b0;
    repeat (3) begin step(); if (irq) irqs++; end
    chk("R10", "no capture pending", capture, 16'd7);
    chk("R10", "no irq pending", 16'(irqs), 16'd0);
    pulses(1);
    chk("R3", "trigger loads zero", count, 16'd0);
    chk("R3", "no irq with mode 0", 16'(irq), 16'd0);
    pulses(2);
    chk("R4", "count after trigger", count, 16'd2);
  endtask

  task automatic t_wrap();
    int irqs;
    irqs = 0;
    cnt_en = 1'b1;
    repeat (65533) begin step(); if (irq) irqs++; end
    chk("R4", "count at max", count, 16'hFFFF);
    step(); if (irq) irqs++;
    cnt_en = 1'b0;
    chk("R4", "count wrapped", count, 16'd0);
    step(); if (irq) irqs++;
    chk("R4", "no irq on wrap", 16'(irqs), 16'd0);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1; step();
    t_reset();
    t_start_irq();
    t_count_and_rise();
    t_select();
    t_filter();
    t_stop();
    t_pending();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1500us;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule